// File: doc/BRIEF.md
# FRAM Power-Up and Sleep Sequencer

This block sits between a power-good indication and the access controller of a parallel ferroelectric memory that has an active-low sleep pin. It keeps the memory's chip-enable forced high and withholds a ready flag from the access controller until the memory may be used: for a fixed wake interval after supply becomes valid, for the whole of a sleep period, and for the same wake interval after the sleep pin is released. Every minimum interval is given in nanoseconds and converted to clock cycles, rounded up, from a clock-frequency parameter.

A sleep request is honoured only between accesses. If one arrives while the access controller reports busy, the sleep pin stays high until the access ends, and the ready flag drops at once so that no new access begins. A power-off request forces chip-enable high and raises a power-off-safe flag once the guard time has passed. Losing power-good in any state sends the sequencer back to its power-up wait and restarts the count.

Top module: `fram_pwr_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), the registered outputs take `zz_n`=1, `ce_force`=1, `ready`=0, `pd_safe`=0.
- R2: After power-up, `ready` rises at the WAKE_CYC-th consecutive rising edge that samples `pwr_good` high, where WAKE_CYC = ceil(WAKE_NS * CLK_HZ / 1e9). Until then `ce_force` is 1; once `ready` is 1, `ce_force` is 0.
- R3: An edge that samples `pwr_good` low puts the outputs, from that edge on, into the power-up values of R1 and restarts the R2 count from zero, whatever the state was.
- R4: In standby (ready, access controller idle, no power-off request), an edge that samples `sleep_req` high drives `zz_n` low, `ce_force` high and `ready` low.
- R5: `zz_n` stays low for at least SLP_CYC = ceil(SLEEP_MIN_NS * CLK_HZ / 1e9) cycles even if `sleep_req` drops earlier, and stays low for as long as `sleep_req` is held after that.
- R6: From the edge where `zz_n` returns high, `ce_force` stays 1 and `ready` stays 0 for WAKE_CYC cycles. `ready` then rises.
- R7: While `ctrl_busy` is high, `zz_n` never falls. A pending sleep or power-off request drops `ready` at the next edge. The sleep pin falls at the edge that first samples `ctrl_busy` low.
- R8: When `ctrl_busy` and `sleep_req` are first sampled high at the same edge in standby, the access wins: `zz_n` stays high until the access ends.
- R9: Whenever `ready` is 1, `zz_n` is 1 and `ce_force` is 0.
- R10: A power-off request (`pd_req`) from standby, or from an access once it ends, sets `ce_force` at the next edge and takes priority over `sleep_req`. `pd_safe` rises OFF_CYC = ceil(OFF_GUARD_NS * CLK_HZ / 1e9) edges later.
- R11: Dropping `pd_req` in the power-off state returns the block to standby with `ready`=1 and `pd_safe`=0 at the next edge. `pd_req` has no effect during power-up, sleep or wake, where `pd_safe` stays 0.
- R12: During an access with no pending request, `ready` stays 1 and `ce_force` stays 0. The block returns to standby when `ctrl_busy` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply valid indication |
| sleep_req | input | 1 | Level request to enter sleep |
| pd_req | input | 1 | Level request to prepare for power removal |
| ctrl_busy | input | 1 | Access controller has an access in progress |
| zz_n | output | 1 | Active-low sleep pin for the memory |
| ce_force | output | 1 | Forces the memory chip-enable inactive (high) |
| ready | output | 1 | Access controller may start an access |
| pd_safe | output | 1 | Guard time met; supply may be removed |

## Verification
The critical collision is an access starting in the same cycle a sleep request arrives. At that moment ready is still high, so the controller is allowed to begin. The bench raises `ctrl_busy` and `sleep_req` on the same falling edge in standby. It expects the sleep pin to stay high and ready to drop at once, and the pin to fall only at the edge that first samples the access finished. A second overlap, power-good vanishing in the middle of a sleep, must release the sleep pin and restart the full wake count instead of finishing the sleep minimum. A behavioural model compares all four outputs every cycle.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_BUSY  = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WAKE  = 3'd4,
    ST_POFF  = 3'd5
  } fps_state_e;

  typedef struct packed {
    logic zz_n;
    logic ce_force;
    logic ready;
    logic pd_safe;
  } fps_out_t;

  localparam fps_out_t FPS_OUT_RESET = '{zz_n: 1'b1, ce_force: 1'b1, ready: 1'b0, pd_safe: 1'b0};

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic longint unsigned ns2cyc(input longint unsigned ns, input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 64'd0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] last,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = (cnt >= last);

  // Counts cycles spent in the current timed state; saturates once done.
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (!done)
      cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/fps_next.sv
module fps_next
  import fps_pkg::*;
(
  input  fps_state_e st,
  input  logic       pwr_good,
  input  logic       sleep_req,
  input  logic       pd_req,
  input  logic       ctrl_busy,
  input  logic       done,
  output fps_state_e nxt
);
  always_comb begin
    nxt = st;
    if (!pwr_good) begin
      nxt = ST_PWRUP;
    end else begin
      unique case (st)
        ST_PWRUP: if (done) nxt = ST_IDLE;
        ST_IDLE: begin
          // An access started alongside a request wins; the request waits.
          if (ctrl_busy)      nxt = ST_BUSY;
          else if (pd_req)    nxt = ST_POFF;
          else if (sleep_req) nxt = ST_SLEEP;
        end
        ST_BUSY: begin
          if (!ctrl_busy) begin
            if (pd_req)         nxt = ST_POFF;
            else if (sleep_req) nxt = ST_SLEEP;
            else                nxt = ST_IDLE;
          end
        end
        ST_SLEEP: if (done && !sleep_req) nxt = ST_WAKE;
        ST_WAKE:  if (done) nxt = ST_IDLE;
        ST_POFF:  if (!pd_req) nxt = ST_IDLE;
        default:  nxt = ST_PWRUP;
      endcase
    end
  end
endmodule

// File: rtl/fps_outreg.sv
module fps_outreg
  import fps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  fps_state_e st,
  input  fps_state_e nxt,
  input  logic       done,
  input  logic       sleep_req,
  input  logic       pd_req,
  output fps_out_t   q
);
  fps_out_t d;

  always_comb begin
    d.zz_n     = (nxt != ST_SLEEP);
    d.ce_force = (nxt == ST_PWRUP) || (nxt == ST_SLEEP) ||
                 (nxt == ST_WAKE)  || (nxt == ST_POFF);
    d.ready    = (nxt == ST_IDLE) ||
                 ((nxt == ST_BUSY) && !sleep_req && !pd_req);
    d.pd_safe  = (nxt == ST_POFF) && (st == ST_POFF) && done;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= FPS_OUT_RESET;
    else     q <= d;
  end
endmodule

// File: rtl/fram_pwr_seq.sv
module fram_pwr_seq
  import fps_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned WAKE_NS      = 450_000,
  parameter int unsigned SLEEP_MIN_NS = 1_000,
  parameter int unsigned OFF_GUARD_NS = 85
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic sleep_req,
  input  logic pd_req,
  input  logic ctrl_busy,
  output logic zz_n,
  output logic ce_force,
  output logic ready,
  output logic pd_safe
);
  localparam int unsigned WAKE_CYC = 32'(ns2cyc(64'(WAKE_NS), 64'(CLK_HZ)));
  localparam int unsigned SLP_CYC  = 32'(ns2cyc(64'(SLEEP_MIN_NS), 64'(CLK_HZ)));
  localparam int unsigned OFF_CYC  = 32'(ns2cyc(64'(OFF_GUARD_NS), 64'(CLK_HZ)));
  localparam int unsigned MAX_A    = (WAKE_CYC > SLP_CYC) ? WAKE_CYC : SLP_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > OFF_CYC) ? MAX_A : OFF_CYC;
  localparam int unsigned CW       = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  fps_state_e    st, nxt;
  logic          done, clr;
  logic [CW-1:0] last;
  fps_out_t      oq;

  always_comb begin
    unique case (st)
      ST_PWRUP, ST_WAKE: last = CW'(WAKE_CYC - 1);
      ST_SLEEP:          last = CW'(SLP_CYC - 1);
      ST_POFF:           last = CW'(OFF_CYC - 1);
      default:           last = '0;
    endcase
  end

  assign clr = (nxt != st) || !pwr_good;

  fps_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .last (last),
    .done (done)
  );

  fps_next u_next (
    .st        (st),
    .pwr_good  (pwr_good),
    .sleep_req (sleep_req),
    .pd_req    (pd_req),
    .ctrl_busy (ctrl_busy),
    .done      (done),
    .nxt       (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) st <= ST_PWRUP;
    else     st <= nxt;
  end

  fps_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .nxt       (nxt),
    .done      (done),
    .sleep_req (sleep_req),
    .pd_req    (pd_req),
    .q         (oq)
  );

  assign zz_n     = oq.zz_n;
  assign ce_force = oq.ce_force;
  assign ready    = oq.ready;
  assign pd_safe  = oq.pd_safe;
endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
  parameter int unsigned WAKE_CYC = 2,
  parameter int unsigned SLP_CYC  = 1
) (
  input logic clk,
  input logic rst,
  input logic pwr_good,
  input logic sleep_req,
  input logic pd_req,
  input logic ctrl_busy,
  input logic zz_n,
  input logic ce_force,
  input logic ready,
  input logic pd_safe
);
  localparam int unsigned HW = $clog2(WAKE_CYC + 1);
  localparam int unsigned LW = $clog2(SLP_CYC + 1);

  logic [HW-1:0] hi_run;
  logic [LW-1:0] lo_run;
  logic          need_wake;

  always_ff @(posedge clk) begin
    if (rst || !ce_force || !zz_n || !pwr_good) hi_run <= '0;
    else if (hi_run < HW'(WAKE_CYC))            hi_run <= hi_run + HW'(1);

    if (rst || zz_n)                  lo_run <= '0;
    else if (lo_run < LW'(SLP_CYC))   lo_run <= lo_run + LW'(1);

    if (rst || !pwr_good || !zz_n)    need_wake <= 1'b1;
    else if (ready)                   need_wake <= 1'b0;
  end

  assert_rst_vals_R1: assert property (@(posedge clk)
    $past(rst) |-> zz_n && ce_force && !ready && !pd_safe);

  assert_wake_time_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && need_wake) |-> (hi_run >= HW'(WAKE_CYC)));

  assert_power_loss_R3: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> zz_n && ce_force && !ready && !pd_safe);

  assert_sleep_ce_R4: assert property (@(posedge clk) disable iff (rst)
    !zz_n |-> ce_force && !ready);

  assert_sleep_min_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(zz_n) && $past(pwr_good) && !$past(rst)) |-> (lo_run >= LW'(SLP_CYC)));

  assert_defer_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(zz_n) |-> !$past(ctrl_busy) && $past(sleep_req));

  assert_ready_clean_R9: assert property (@(posedge clk) disable iff (rst)
    ready |-> zz_n && !ce_force);

  assert_off_safe_R10: assert property (@(posedge clk) disable iff (rst)
    pd_safe |-> ce_force && zz_n && !ready && $past(pd_req));
endmodule

bind fram_pwr_seq fps_chk #(.WAKE_CYC(WAKE_CYC), .SLP_CYC(SLP_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_good  (pwr_good),
  .sleep_req (sleep_req),
  .pd_req    (pd_req),
  .ctrl_busy (ctrl_busy),
  .zz_n      (zz_n),
  .ce_force  (ce_force),
  .ready     (ready),
  .pd_safe   (pd_safe)
);

// File: tb/fram_pwr_seq_test.sv
module fram_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;
  // Bench configuration: 2 MHz clock, 450 us wake, 3 us sleep minimum, 2 us guard.
  // ceil(450000*2e6/1e9)=900, ceil(3000*2e6/1e9)=6, ceil(2000*2e6/1e9)=4.
  localparam int W_CYC = 900;
  localparam int S_CYC = 6;
  localparam int P_CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b0, sleep_req = 1'b0, pd_req = 1'b0, ctrl_busy = 1'b0;
  logic zz_n, ce_force, ready, pd_safe;

  fram_pwr_seq #(
    .CLK_HZ(2_000_000), .WAKE_NS(450_000), .SLEEP_MIN_NS(3_000), .OFF_GUARD_NS(2_000)
  ) uut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .sleep_req(sleep_req),
    .pd_req(pd_req), .ctrl_busy(ctrl_busy),
    .zz_n(zz_n), .ce_force(ce_force), .ready(ready), .pd_safe(pd_safe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";
  bit    live = 1'b0;
  bit    finished = 1'b0;

  // Behavioural reference: 0 power-up, 1 idle, 2 access, 3 sleep, 4 wake, 5 power-off.
  int mode = 0;
  int t = 0;
  bit e_zz = 1'b1, e_ce = 1'b1, e_rdy = 1'b0, e_safe = 1'b0;

  always @(posedge clk) begin
    if (rst || !pwr_good) begin
      mode = 0; t = 0;
    end else begin
      case (mode)
        0: begin t++; if (t >= W_CYC) begin mode = 1; t = 0; end end
        1: begin
          if (ctrl_busy) mode = 2;
          else if (pd_req) begin mode = 5; t = 0; end
          else if (sleep_req) begin mode = 3; t = 0; end
        end
        2: if (!ctrl_busy) begin
          if (pd_req) begin mode = 5; t = 0; end
          else if (sleep_req) begin mode = 3; t = 0; end
          else mode = 1;
        end
        3: begin t++; if (t >= S_CYC && !sleep_req) begin mode = 4; t = 0; end end
        4: begin t++; if (t >= W_CYC) begin mode = 1; t = 0; end end
        default: begin if (!pd_req) begin mode = 1; t = 0; end else t++; end
      endcase
    end
    e_zz   = (mode != 3);
    e_ce   = (mode == 0) || (mode >= 3);
    e_rdy  = (mode == 1) || (mode == 2 && !sleep_req && !pd_req);
    e_safe = (mode == 5) && (t >= P_CYC);
    live   = 1'b1;
  end

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !finished)
      check(tag, "model {zz_n,ce_force,ready,pd_safe}",
            {zz_n, ce_force, ready, pd_safe}, {e_zz, e_ce, e_rdy, e_safe});
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pin(input string req, input string what, input logic act, input logic exp);
    check(req, what, {3'b000, act}, {3'b000, exp});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    tag = "R1";
    check("R1", "reset outputs", {zz_n, ce_force, ready, pd_safe}, 4'b1100);
    rst = 1'b0;
    step(2);
    // R2: cold power-up count
    tag = "R2"; pwr_good = 1'b1;
    step(W_CYC - 1); pin("R2", "ready before wake count", ready, 1'b0);
    pin("R2", "ce_force before wake count", ce_force, 1'b1);
    step(1); pin("R2", "ready after wake count", ready, 1'b1);
    pin("R2", "ce_force after wake count", ce_force, 1'b0);
    // R12: plain access
    tag = "R12"; ctrl_busy = 1'b1;
    step(2); pin("R12", "ready during access", ready, 1'b1);
    pin("R12", "ce_force during access", ce_force, 1'b0);
    ctrl_busy = 1'b0; step(1); pin("R12", "ready after access", ready, 1'b1);
    // R7: sleep deferred behind an access
    tag = "R7"; ctrl_busy = 1'b1; step(1);
    sleep_req = 1'b1; step(3);
    pin("R7", "zz_n held while busy", zz_n, 1'b1);
    pin("R7", "ready dropped while pending", ready, 1'b0);
    ctrl_busy = 1'b0; step(1); pin("R7", "zz_n after access end", zz_n, 1'b0);
    // R5: minimum sleep with an early release
    tag = "R5"; sleep_req = 1'b0;
    step(S_CYC - 1); pin("R5", "zz_n inside minimum", zz_n, 1'b0);
    step(1); pin("R5", "zz_n after minimum", zz_n, 1'b1);
    // R6: wake interval
    tag = "R6";
    pin("R6", "ce_force at wake start", ce_force, 1'b1);
    step(W_CYC - 1); pin("R6", "ready before wake ends", ready, 1'b0);
    step(1); pin("R6", "ready after wake", ready, 1'b1);
    // R4 / R5: sleep from standby, held long
    tag = "R4"; sleep_req = 1'b1; step(1);
    pin("R4", "zz_n low on request", zz_n, 1'b0);
    pin("R4", "ce_force in sleep", ce_force, 1'b1);
    tag = "R5"; step(S_CYC + 5); pin("R5", "zz_n held by request", zz_n, 1'b0);
    sleep_req = 1'b0; step(1); pin("R5", "zz_n on release", zz_n, 1'b1);
    // R11: power-off request ignored during wake
    tag = "R11"; pd_req = 1'b1; step(3);
    pin("R11", "pd_safe during wake", pd_safe, 1'b0);
    pin("R11", "ready during wake", ready, 1'b0);
    pd_req = 1'b0;
    step(W_CYC - 4); pin("R6", "ready before second wake ends", ready, 1'b0);
    step(1); pin("R6", "ready after second wake", ready, 1'b1);
    // R8: access and sleep request in the same cycle
    tag = "R8"; ctrl_busy = 1'b1; sleep_req = 1'b1; step(1);
    pin("R8", "zz_n when access wins", zz_n, 1'b1);
    pin("R8", "ready with pending sleep", ready, 1'b0);
    ctrl_busy = 1'b0; step(1); pin("R8", "zz_n after access", zz_n, 1'b0);
    sleep_req = 1'b0;
    step(S_CYC + W_CYC - 1); pin("R8", "ready before wake ends", ready, 1'b0);
    step(1); pin("R8", "ready after wake", ready, 1'b1);
    // R10: power-off beats sleep
    tag = "R10"; pd_req = 1'b1; sleep_req = 1'b1; step(1);
    pin("R10", "ce_force on power-off", ce_force, 1'b1);
    pin("R10", "zz_n stays high", zz_n, 1'b1);
    step(P_CYC - 1); pin("R10", "pd_safe before guard", pd_safe, 1'b0);
    step(1); pin("R10", "pd_safe after guard", pd_safe, 1'b1);
    tag = "R11"; pd_req = 1'b0; sleep_req = 1'b0; step(1);
    check("R11", "release power-off", {ce_force, ready, pd_safe}, {1'b0, 1'b1, 1'b0});
    // R10: power-off deferred behind an access
    tag = "R10"; ctrl_busy = 1'b1; step(1);
    pd_req = 1'b1; step(2);
    pin("R10", "ce_force while busy", ce_force, 1'b0);
    pin("R10", "ready while power-off pending", ready, 1'b0);
    ctrl_busy = 1'b0; step(1); pin("R10", "ce_force after access", ce_force, 1'b1);
    step(P_CYC - 1); pin("R10", "pd_safe before guard", pd_safe, 1'b0);
    step(1); pin("R10", "pd_safe after guard", pd_safe, 1'b1);
    pd_req = 1'b0; step(1); pin("R11", "ready after release", ready, 1'b1);
    // R3: power loss in standby
    tag = "R3"; pwr_good = 1'b0; step(1);
    check("R3", "loss in standby", {zz_n, ce_force, ready, pd_safe}, 4'b1100);
    pwr_good = 1'b1;
    step(W_CYC - 1); pin("R3", "ready before restart count", ready, 1'b0);
    step(1); pin("R3", "ready after restart count", ready, 1'b1);
    // R3: power loss during sleep
    sleep_req = 1'b1; step(2); pin("R3", "zz_n asleep", zz_n, 1'b0);
    pwr_good = 1'b0; step(1);
    check("R3", "loss in sleep", {zz_n, ce_force, ready, pd_safe}, 4'b1100);
    pwr_good = 1'b1; sleep_req = 1'b0;
    step(W_CYC - 1); pin("R3", "ready before count", ready, 1'b0);
    step(1); pin("R3", "ready after count", ready, 1'b1);
    // R3: glitch in the middle of power-up restarts the count
    pwr_good = 1'b0; step(1); pwr_good = 1'b1; step(W_CYC / 2);
    pwr_good = 1'b0; step(1); pwr_good = 1'b1;
    step(W_CYC - 1); pin("R3", "ready before full recount", ready, 1'b0);
    step(1); pin("R3", "ready after full recount", ready, 1'b1);
    pin("R9", "zz_n with ready", zz_n, 1'b1);
    step(2);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule